// File: doc/BRIEF.md
# I2C Sampling Converter Sequencer

This block is the digital controller of a sampling converter that hangs on a two-wire I2C bus. It runs the converter through three phases: a timed conversion, a low-activity sleep that holds the last result, and a bus transfer. During the bus transfer the master either reads the 24-bit result word or writes a byte that selects the analogue input pair. The conversion length is counted in ticks of a conversion-clock enable. A behavioural model of the analogue core presents a signed result on a parallel bus, and the block captures it on the cycle the count runs out.

The block refuses the bus while a conversion runs. It does not acknowledge any address, so a master learns that the result is not ready from the missing acknowledge. The next conversion starts when the previous bus transaction ends. That end can be a fully read word, a read that the master broke off with a stop, or a stop that follows an acknowledged write. Several devices share one global write address, so a single write to it makes all of them start converting together. SCL and SDA are sampled in the system clock domain. SDA is driven open-drain: `sda_oe_o` high pulls the line low.

Top module: `adc_i2c_seq`

## Requirements
- R1: In the first cycle after reset is released, a conversion starts. `busy_o` goes high, and the active pair is positive 0, negative 1.
- R2: A conversion lasts exactly CONV_CYCLES cycles in which `conv_tick_i` is high while `busy_o` is high. At the end `busy_o` falls and `result_i` is captured.
- R3: While `busy_o` is high, no address is acknowledged, whether it is the device's own address or the global one. SDA stays released.
- R4: While idle, the device acknowledges its own address for both read and write. It acknowledges the global address (default 7'h77) for write only. It acknowledges no other address.
- R5: A read returns 24 bits, MSB first. Bit 23 is 0, bit 22 is the captured sign (`result_i[16]`), bits 21:6 are the captured magnitude (`result_i[15:0]`), and bits 5:0 are 0. SDA changes only after a falling SCL edge. The master acknowledges after bits 23..16 and 15..8.
- R6: While no conversion runs, the captured result does not change, whatever `result_i` does.
- R7: When the falling SCL edge that ends the 24th bit is detected, a new conversion starts without waiting for a stop.
- R8: A stop that ends a read before all 24 bits have been clocked out starts a new conversion.
- R9: A stop after an acknowledged write, to the own or the global address, starts a new conversion.
- R10: A channel byte with bit 7 set is decoded as follows. If bit 6 is set, the pair is single-ended: positive is channel bits[3:0] and negative is the common input (code 16). If bit 6 is clear, the pair is differential with pair index p = bits[2:0]: bit 5 = 0 gives positive 2p and negative 2p+1, and bit 5 = 1 swaps them. The new pair becomes active only when the next conversion starts.
- R11: A channel byte with bit 7 clear leaves the pair unchanged.
- R12: The own address is {BASE_ADDR[6:3], the address pins sampled in the first cycle after reset}. Later changes on the pins have no effect.
- R13: A stop after a non-acknowledged address does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_pins_i | input | ADDR_PINS | Address select pins, sampled once after reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| conv_tick_i | input | 1 | Conversion clock enable, one cycle per conversion clock |
| result_i | input | RES_W+1 | Sign (MSB) and magnitude from the analogue core model |
| busy_o | output | 1 | Conversion in progress |
| pos_ch_o | output | CODE_W | Active positive input code (16 = common) |
| neg_ch_o | output | CODE_W | Active negative input code (16 = common) |

## Verification
The assertions check the following on every cycle:
- no address acknowledge is ever driven while a conversion runs;
- SDA is released in the idle and address phases;
- during a read, SDA moves only on a detected falling SCL edge;
- the captured result and the active pair change only at the end or the start of a conversion;
- the tick counter stays in range.

Only the bench scenarios can show the rest:
- the word layout and the bit order on the wire;
- that each of the three transaction endings restarts the converter, and that a stop after a refused address does not;
- the channel byte decoding;
- that the address is taken from the pins once after reset.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WR,
    S_WR_ACK,
    S_RD,
    S_RD_ACK
  } bus_state_e;
endpackage

// File: rtl/adc_seq_line_sync.sv
module adc_seq_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic scl_q, sda_q, scl_n, sda_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
      scl_q <= scl_n;
      sda_q <= sda_n;
    end
  end

  assign scl_n      = scl_s[SYNC_STAGES-1];
  assign sda_n      = sda_s[SYNC_STAGES-1];
  assign scl_rise_o = scl_n & ~scl_q;
  assign scl_fall_o = ~scl_n & scl_q;
  // SDA edges while SCL is held high mark bus conditions
  assign start_o    = scl_n & scl_q & sda_q & ~sda_n;
  assign stop_o     = scl_n & scl_q & ~sda_q & sda_n;
  assign sda_o      = sda_n;
endmodule

// File: rtl/adc_seq_conv_timer.sv
module adc_seq_conv_timer #(
  parameter int unsigned CONV_CYCLES = 41036,
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (cnt_q == CNT_W'(CONV_CYCLES - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(CONV_CYCLES));
  assert_done_ends_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/adc_seq_chan_dec.sv
module adc_seq_chan_dec #(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned CODE_W = CH_W + 1
) (
  input  logic [7:0]        cmd_i,
  output logic              upd_o,
  output logic [CODE_W-1:0] pos_o,
  output logic [CODE_W-1:0] neg_o
);
  localparam logic [CODE_W-1:0] COM_CODE = CODE_W'(NUM_CH);
  logic [CH_W-2:0] pair;

  assign pair  = cmd_i[CH_W-2:0];
  assign upd_o = cmd_i[7];

  always_comb begin
    if (cmd_i[6]) begin
      pos_o = {1'b0, cmd_i[CH_W-1:0]};
      neg_o = COM_CODE;
    end else begin
      // bit 5 swaps the polarity of the even/odd pair
      pos_o = {1'b0, pair, cmd_i[5]};
      neg_o = {1'b0, pair, ~cmd_i[5]};
    end
  end
endmodule

// File: rtl/adc_seq_bus_slave.sv
module adc_seq_bus_slave
  import adc_seq_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter logic [6:0]  GLOBAL_ADDR = 7'h77,
  localparam int unsigned RC_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [6:0]        own_addr_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sda_oe_o,
  output logic [7:0]        byte_o,
  output logic              byte_vld_o,
  output logic              restart_o
);
  bus_state_e state_q;
  logic [7:0] shreg_q;
  logic [3:0] bit_cnt_q;
  logic [RC_W-1:0] rd_cnt_q, rd_nxt;
  logic oe_q, rnw_q, mack_q, wr_valid_q, rd_active_q, restart_q, byte_vld_q;
  logic [7:0] byte_q;
  logic addr_hit;
  logic [RC_W-1:0] idx_nxt, idx_cur;

  assign rd_nxt  = rd_cnt_q + RC_W'(1);
  assign idx_nxt = RC_W'(WORD_W - 1) - rd_nxt;
  assign idx_cur = RC_W'(WORD_W - 1) - rd_cnt_q;
  assign addr_hit = !busy_i && ((shreg_q[7:1] == own_addr_i) ||
                                (shreg_q[7:1] == GLOBAL_ADDR && !shreg_q[0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      shreg_q     <= '0;
      bit_cnt_q   <= '0;
      rd_cnt_q    <= '0;
      oe_q        <= 1'b0;
      rnw_q       <= 1'b0;
      mack_q      <= 1'b0;
      wr_valid_q  <= 1'b0;
      rd_active_q <= 1'b0;
      restart_q   <= 1'b0;
      byte_vld_q  <= 1'b0;
      byte_q      <= '0;
    end else begin
      restart_q  <= 1'b0;
      byte_vld_q <= 1'b0;
      if (start_i || stop_i) begin
        // a finished write or a broken-off read triggers the next conversion
        restart_q   <= wr_valid_q | rd_active_q;
        wr_valid_q  <= 1'b0;
        rd_active_q <= 1'b0;
        oe_q        <= 1'b0;
        bit_cnt_q   <= '0;
        state_q     <= start_i ? S_ADDR : S_IDLE;
      end else if (scl_rise_i) begin
        case (state_q)
          S_ADDR, S_WR: begin
            if (bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
          S_RD_ACK: mack_q <= ~sda_i;
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (state_q)
          S_ADDR: begin
            if (bit_cnt_q == 4'd8) begin
              if (addr_hit) begin
                oe_q    <= 1'b1;
                rnw_q   <= shreg_q[0];
                state_q <= S_ADDR_ACK;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          S_ADDR_ACK: begin
            if (rnw_q) begin
              state_q     <= S_RD;
              rd_active_q <= 1'b1;
              rd_cnt_q    <= '0;
              oe_q        <= ~word_i[WORD_W-1];
            end else begin
              state_q    <= S_WR;
              wr_valid_q <= 1'b1;
              bit_cnt_q  <= '0;
              oe_q       <= 1'b0;
            end
          end
          S_WR: begin
            if (bit_cnt_q == 4'd8) begin
              byte_q     <= shreg_q;
              byte_vld_q <= 1'b1;
              oe_q       <= 1'b1;
              state_q    <= S_WR_ACK;
            end
          end
          S_WR_ACK: begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= S_WR;
          end
          S_RD: begin
            rd_cnt_q <= rd_nxt;
            if (rd_nxt == RC_W'(WORD_W)) begin
              restart_q   <= 1'b1;
              rd_active_q <= 1'b0;
              oe_q        <= 1'b0;
              state_q     <= S_IDLE;
            end else if (rd_nxt[2:0] == 3'd0) begin
              oe_q    <= 1'b0;
              state_q <= S_RD_ACK;
            end else begin
              oe_q <= ~word_i[idx_nxt];
            end
          end
          S_RD_ACK: begin
            if (mack_q) begin
              state_q <= S_RD;
              oe_q    <= ~word_i[idx_cur];
            end else begin
              state_q <= S_IDLE;
              oe_q    <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign byte_o     = byte_q;
  assign byte_vld_o = byte_vld_q;
  assign restart_o  = restart_q;

  assert_no_ack_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ADDR_ACK) |-> !busy_i);
  assert_released_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE || state_q == S_ADDR) |-> !oe_q);
  assert_data_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD && !scl_fall_i && !start_i && !stop_i) |=> $stable(oe_q));
  assert_rd_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_q <= RC_W'(WORD_W));
endmodule

// File: rtl/adc_i2c_seq.sv
module adc_i2c_seq #(
  parameter int unsigned NUM_CH      = 16,
  parameter int unsigned CONV_CYCLES = 41036,
  parameter int unsigned ADDR_PINS   = 3,
  parameter logic [6:0]  BASE_ADDR   = 7'h14,
  parameter logic [6:0]  GLOBAL_ADDR = 7'h77,
  parameter int unsigned RES_W       = 16,
  localparam int unsigned CODE_W = $clog2(NUM_CH) + 1,
  localparam int unsigned WORD_W = 24,
  localparam int unsigned PAD_W  = WORD_W - 2 - RES_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_PINS-1:0] addr_pins_i,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 conv_tick_i,
  input  logic [RES_W:0]       result_i,
  output logic                 busy_o,
  output logic [CODE_W-1:0]    pos_ch_o,
  output logic [CODE_W-1:0]    neg_ch_o
);
  logic scl_rise, scl_fall, bus_start, bus_stop, sda_s;
  logic busy, conv_done, conv_start, restart;
  logic boot_q, addr_cap_q;
  logic [6:0] own_addr_q;
  logic [7:0] cmd_byte;
  logic cmd_vld, dec_upd;
  logic [CODE_W-1:0] dec_pos, dec_neg, pend_pos_q, pend_neg_q, pos_q, neg_q;
  logic [RES_W:0] res_q;
  logic [WORD_W-1:0] word;

  adc_seq_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop), .sda_o(sda_s)
  );

  adc_seq_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(conv_start),
    .tick_i(conv_tick_i), .busy_o(busy), .done_o(conv_done)
  );

  adc_seq_bus_slave #(.WORD_W(WORD_W), .GLOBAL_ADDR(GLOBAL_ADDR)) u_slave (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .sda_i(sda_s),
    .own_addr_i(own_addr_q), .busy_i(busy), .word_i(word),
    .sda_oe_o(sda_oe_o), .byte_o(cmd_byte), .byte_vld_o(cmd_vld),
    .restart_o(restart)
  );

  adc_seq_chan_dec #(.NUM_CH(NUM_CH)) u_dec (
    .cmd_i(cmd_byte), .upd_o(dec_upd), .pos_o(dec_pos), .neg_o(dec_neg)
  );

  assign conv_start = ~boot_q | restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q     <= 1'b0;
      addr_cap_q <= 1'b0;
      own_addr_q <= '0;
    end else begin
      boot_q <= 1'b1;
      if (!addr_cap_q) begin
        own_addr_q <= {BASE_ADDR[6:ADDR_PINS], addr_pins_i};
        addr_cap_q <= 1'b1;
      end
    end
  end

  // pending pair is written over the bus, active pair follows at conversion start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_pos_q <= CODE_W'(0);
      pend_neg_q <= CODE_W'(1);
      pos_q      <= CODE_W'(0);
      neg_q      <= CODE_W'(1);
      res_q      <= '0;
    end else begin
      if (cmd_vld && dec_upd) begin
        pend_pos_q <= dec_pos;
        pend_neg_q <= dec_neg;
      end
      if (conv_start) begin
        pos_q <= pend_pos_q;
        neg_q <= pend_neg_q;
      end
      if (conv_done) res_q <= result_i;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {1'b0, res_q, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign word = {1'b0, res_q};
    end
  endgenerate

  assign busy_o   = busy;
  assign pos_ch_o = pos_q;
  assign neg_ch_o = neg_q;

  assert_pair_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_start |=> ($stable(pos_q) && $stable(neg_q)));
  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done |=> $stable(res_q));
  assert_start_from_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start && boot_q) |-> !busy);
  assert_addr_fixed_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_cap_q |=> $stable(own_addr_q));
endmodule

// File: tb/sim_adc_i2c_seq.sv
module sim_adc_i2c_seq;
  localparam int unsigned CONV = 400;
  localparam int H = 6;
  localparam logic [6:0] BASE = 7'h14;
  localparam logic [6:0] GADDR = 7'h77;
  localparam logic [2:0] PINS0 = 3'b101;
  localparam logic [6:0] OWN = {BASE[6:3], PINS0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, tick = 1'b0;
  logic [2:0] pins = PINS0;
  logic [16:0] res_in = '0;
  logic sda_oe, busy;
  logic [4:0] pos, neg;
  wire sda_line = sda_m & ~sda_oe;

  adc_i2c_seq #(.CONV_CYCLES(CONV), .BASE_ADDR(BASE), .GLOBAL_ADDR(GADDR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_pins_i(pins),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .conv_tick_i(tick), .result_i(res_in), .busy_o(busy),
    .pos_ch_o(pos), .neg_ch_o(neg)
  );

  int n_tests = 0, n_fail = 0;
  int run_len = 0, last_len = 0;

  always @(negedge clk) tick <= ($urandom_range(2, 0) == 0);

  always @(posedge clk) begin
    if (busy && tick) run_len <= run_len + 1;
    else if (!busy && run_len != 0) begin
      last_len <= run_len;
      run_len  <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input logic [16:0] r);
    return {1'b0, r[16], r[15:0], 6'b0};
  endfunction

  function automatic logic [9:0] exp_pair(input logic [7:0] c, input logic [9:0] cur);
    if (!c[7]) return cur;
    if (c[6]) return {1'b0, c[3:0], 5'd16};
    return {1'b0, c[2:0], c[5], 1'b0, c[2:0], ~c[5]};
  endfunction

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b0; hp();
    scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; hp();
    scl_m = 1'b1; hp();
    s = sda_line;
    scl_m = 1'b0; hp();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic mack);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~mack, s);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rnw, output logic ack);
    bus_start();
    write_byte({a, rnw}, ack);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic ack;
    logic [7:0] b0, b1, b2;
    logic [9:0] pair_exp;
    logic [16:0] latched;
    logic [7:0] cmd;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pins = 3'b010;  // R12: later pin changes must be ignored
    chk("R1 busy after reset", busy, 1);
    chk("R1 default pos", pos, 0);
    chk("R1 default neg", neg, 1);
    pair_exp = {5'd0, 5'd1};

    res_in = 17'h1_A5C3;
    send_addr(OWN, 1'b1, ack);
    chk("R3 own read nack while busy", ack, 0);
    bus_stop();
    send_addr(GADDR, 1'b0, ack);
    chk("R3 global write nack while busy", ack, 0);
    bus_stop();
    chk("R13 still converting", busy, 1);
    wait_idle();
    chk("R2 conversion tick count", last_len, CONV);
    latched = 17'h1_A5C3;

    res_in = 17'h0_1234;
    repeat (50) @(negedge clk);
    chk("R6 sleep stays idle", busy, 0);
    send_addr(OWN, 1'b1, ack);
    chk("R4 own read ack", ack, 1);
    read_byte(b0, 1'b1);
    read_byte(b1, 1'b1);
    read_byte(b2, 1'b0);
    chk("R5 R6 word held", {b0, b1, b2}, exp_word(latched));
    chk("R7 restart after full read", busy, 1);
    bus_stop();
    wait_idle();
    latched = 17'h0_1234;

    send_addr(OWN, 1'b0, ack);
    chk("R4 own write ack", ack, 1);
    cmd = 8'hA2;
    write_byte(cmd, ack);
    chk("R4 data byte ack", ack, 1);
    chk("R10 pair unchanged before start", {pos, neg}, pair_exp);
    bus_stop();
    chk("R9 restart after write", busy, 1);
    pair_exp = exp_pair(cmd, pair_exp);
    chk("R10 diff swapped pair", {pos, neg}, pair_exp);
    chk("R10 diff pair literal", {pos, neg}, {5'd5, 5'd4});
    wait_idle();

    send_addr(OWN, 1'b0, ack);
    write_byte(8'h4D, ack);
    bus_stop();
    chk("R9 restart after ignored byte", busy, 1);
    chk("R11 pair unchanged", {pos, neg}, {5'd5, 5'd4});
    wait_idle();

    send_addr(OWN, 1'b0, ack);
    write_byte(8'hCD, ack);
    bus_stop();
    pair_exp = {5'd13, 5'd16};
    chk("R10 single-ended pair", {pos, neg}, pair_exp);
    res_in = 17'h1_00FF;
    wait_idle();
    latched = 17'h1_00FF;

    send_addr({BASE[6:3], 3'b010}, 1'b0, ack);
    chk("R12 late pins address nack", ack, 0);
    bus_stop();
    chk("R13 no restart after nack", busy, 0);
    send_addr(7'h10, 1'b1, ack);
    chk("R4 foreign address nack", ack, 0);
    bus_stop();
    send_addr(GADDR, 1'b1, ack);
    chk("R4 global read nack", ack, 0);
    bus_stop();
    chk("R13 no restart after global read", busy, 0);

    send_addr(OWN, 1'b1, ack);
    read_byte(b0, 1'b0);
    chk("R5 first byte", b0, exp_word(latched) >> 16);
    chk("R8 idle before stop", busy, 0);
    bus_stop();
    chk("R8 restart after aborted read", busy, 1);
    res_in = 17'h0_8001;
    wait_idle();
    latched = 17'h0_8001;

    send_addr(GADDR, 1'b0, ack);
    chk("R4 global write ack", ack, 1);
    bus_stop();
    chk("R9 restart after global write", busy, 1);
    wait_idle();

    for (int it = 0; it < 8; it++) begin
      logic [31:0] r;
      r = $urandom;
      send_addr(OWN, 1'b1, ack);
      if (r[20]) begin
        read_byte(b0, 1'b1);
        read_byte(b1, 1'b0);
        chk("R5 partial word", {b0, b1}, exp_word(latched) >> 8);
        bus_stop();
        chk("R8 restart random abort", busy, 1);
      end else begin
        read_byte(b0, 1'b1);
        read_byte(b1, 1'b1);
        read_byte(b2, 1'b0);
        chk("R5 random word", {b0, b1, b2}, exp_word(latched));
        chk("R7 restart random read", busy, 1);
        bus_stop();
      end
      res_in = r[16:0];
      wait_idle();
      latched = r[16:0];
      chk("R2 random tick count", last_len, CONV);
      cmd = r[31:24];
      send_addr(OWN, 1'b0, ack);
      write_byte(cmd, ack);
      bus_stop();
      pair_exp = exp_pair(cmd, pair_exp);
      chk("R10 R11 random pair", {pos, neg}, pair_exp);
      wait_idle();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule